// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a load/store unit and a word-wide memory port. It keeps a direct-mapped array of four-word lines, each with a tag, a line valid bit and one valid bit per word. Load hits are answered in the cycle the request is presented. A load miss fetches the line starting with the requested word and acknowledges the processor when that first word returns. The remaining words are then filled in wrap-around order while the cache stays busy.

Stores always go to memory. A store whose line is present updates the cached word. A store to a line that is absent claims the line: it installs the new tag and marks only the stored word valid. An invalidate pulse drops every line. With the enable input low, every access goes straight to memory and the cache contents are left alone. Addresses are word addresses, split as tag | index | word-in-line, with the word offset in the lowest bits.

Top module: `dcache_wt`

## Requirements
- R1: A load whose tag matches, whose line valid bit is set and whose word valid bit is set is acknowledged in the same cycle with the cached word, and raises no memory request.
- R2: A load that misses on the tag, or hits an invalid line, reads the whole line from memory with the requested word first and then word+1, word+2, word+3 modulo 4. The processor is acknowledged in the cycle the first word's memory acknowledge arrives, with that word as data.
- R3: Once a line fill is complete, a load of any of its four words is a hit.
- R4: A load whose tag matches on a valid line but whose word valid bit is clear issues exactly one memory read, for that word only, and that word then hits.
- R5: Every store, cached or not, issues one memory write with the store's address and data. The processor is acknowledged when the memory acknowledges the write.
- R6: A store to a present line updates the cached word, so a following load of that word hits with the stored data.
- R7: A store to an absent line installs its tag and leaves only the stored word valid. The stored word then hits, and the other words of that line each need one memory read. The line that previously held the index is gone.
- R8: A one-cycle invalidate pulse clears every line valid bit, so a load to a previously resident word misses.
- R9: With enable low, loads and stores go to memory one word at a time and never hit. The cache contents are unchanged: after enable returns high, a word resident before still hits with its old value, even if a bypassed store wrote memory.
- R10: Once raised, the memory request holds its address, data and direction stable until the memory acknowledges it.
- R11: After reset, no line is valid, and both the acknowledge and the memory request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Cache enable; low makes every access bypass |
| inv_i | input | 1 | One-cycle pulse clearing all line valid bits |
| req_i | input | 1 | Processor request, held until ack_o |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Store data |
| ack_o | output | 1 | Request done; rdata_o valid for loads |
| rdata_o | output | DATA_W | Load data |
| mem_req_o | output | 1 | Memory request, held until mem_ack_i |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | One-cycle memory acknowledge |
| mem_rdata_i | input | DATA_W | Memory read data, valid with mem_ack_i |

## Verification
A hit acknowledges combinationally, so the bench samples ack_o 1 time unit after driving a request at the falling edge and expects zero waited edges. A miss, a store and a bypassed access are each due on the fourth rising edge after the request. That is one edge for the controller to capture the request, then three for the bench memory, whose acknowledge is registered with a two-cycle latency. The bench counts falling edges until ack_o and compares that count against these values. Read order and read counts are taken from the memory model's log only after a settle window long enough for any fill to drain.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BYP,
    ST_WR,
    ST_FILL
  } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int NUM_LINES  = 16,
  parameter int LINE_WORDS = 4,
  parameter int TAG_W      = 6,
  parameter int IDX_W      = $clog2(NUM_LINES),
  parameter int OFF_W      = $clog2(LINE_WORDS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  inv_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [TAG_W-1:0]      rd_tag_o,
  output logic                  rd_lvalid_o,
  output logic [LINE_WORDS-1:0] rd_wvalid_o,
  input  logic                  wr_en_i,
  input  logic                  wr_new_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [TAG_W-1:0]      wr_tag_i,
  input  logic [OFF_W-1:0]      wr_word_i
);
  logic [TAG_W-1:0]      tag_q    [NUM_LINES];
  logic [LINE_WORDS-1:0] wvalid_q [NUM_LINES];
  logic [NUM_LINES-1:0]  lvalid_q;
  logic [LINE_WORDS-1:0] word_hot;

  assign word_hot = {{(LINE_WORDS-1){1'b0}}, 1'b1} << wr_word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvalid_q <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        tag_q[i]    <= '0;
        wvalid_q[i] <= '0;
      end
    end else begin
      if (wr_en_i) begin
        if (wr_new_i) begin
          tag_q[wr_idx_i]    <= wr_tag_i;
          wvalid_q[wr_idx_i] <= word_hot;
          lvalid_q[wr_idx_i] <= 1'b1;
        end else begin
          wvalid_q[wr_idx_i] <= wvalid_q[wr_idx_i] | word_hot;
        end
      end
      if (inv_i) lvalid_q <= '0;  // invalidate wins over a same-cycle allocate
    end
  end

  assign rd_tag_o    = tag_q[rd_idx_i];
  assign rd_lvalid_o = lvalid_q[rd_idx_i];
  assign rd_wvalid_o = wvalid_q[rd_idx_i];

  logic [IDX_W-1:0] chk_idx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_idx_q <= '0;
    else         chk_idx_q <= wr_idx_i;
  end

  p_inv_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> lvalid_q == '0)
    else $error("p_inv_clears_r8");

  p_alloc_one_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_new_i) |=> $countones(wvalid_q[chk_idx_q]) == 1)
    else $error("p_alloc_one_word_r7");
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int NUM_LINES  = 16,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  parameter int LA_W       = $clog2(NUM_LINES * LINE_WORDS)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [LA_W-1:0]   waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LA_W-1:0]   raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = NUM_LINES * LINE_WORDS;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int OFF_W      = $clog2(LINE_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lk_hit_i,
  input  logic              lk_line_i,
  input  logic              mem_ack_i,
  output logic [ADDR_W-1:0] lk_addr_o,
  output logic              ack_o,
  output logic              from_mem_o,
  output logic              upd_en_o,
  output logic              upd_new_o,
  output logic              upd_from_mem_o,
  output logic [ADDR_W-1:0] upd_addr_o,
  output logic [DATA_W-1:0] upd_wdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int CNT_W = $clog2(LINE_WORDS + 1);

  dc_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic [OFF_W-1:0]  word_q;
  logic [CNT_W-1:0]  left_q;
  logic              first_q;
  logic              new_q;
  logic [ADDR_W-1:0] fill_addr;

  assign fill_addr   = {addr_q[ADDR_W-1:OFF_W], word_q};
  assign lk_addr_o   = (state_q == ST_IDLE) ? addr_i : addr_q;
  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_WR) || ((state_q == ST_BYP) && we_q);
  assign mem_addr_o  = (state_q == ST_FILL) ? fill_addr : addr_q;
  assign mem_wdata_o = wdata_q;
  assign upd_wdata_o = wdata_q;

  always_comb begin
    ack_o          = 1'b0;
    from_mem_o     = 1'b0;
    upd_en_o       = 1'b0;
    upd_new_o      = 1'b0;
    upd_from_mem_o = 1'b0;
    upd_addr_o     = addr_q;
    unique case (state_q)
      ST_IDLE: ack_o = req_i && enable_i && !we_i && lk_hit_i;
      ST_BYP: begin
        ack_o      = mem_ack_i;
        from_mem_o = 1'b1;
      end
      ST_WR: begin
        ack_o     = mem_ack_i;
        upd_en_o  = mem_ack_i;
        upd_new_o = !lk_line_i;
      end
      ST_FILL: begin
        ack_o          = mem_ack_i && first_q;  // critical word releases the load
        from_mem_o     = 1'b1;
        upd_en_o       = mem_ack_i;
        upd_new_o      = new_q && first_q;
        upd_from_mem_o = 1'b1;
        upd_addr_o     = fill_addr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      word_q  <= '0;
      left_q  <= '0;
      first_q <= 1'b0;
      new_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            we_q    <= we_i;
            if (!enable_i) begin
              state_q <= ST_BYP;
            end else if (we_i) begin
              state_q <= ST_WR;
            end else if (!lk_hit_i) begin
              state_q <= ST_FILL;
              word_q  <= addr_i[OFF_W-1:0];
              left_q  <= lk_line_i ? CNT_W'(1) : CNT_W'(LINE_WORDS);
              first_q <= 1'b1;
              new_q   <= !lk_line_i;
            end
          end
        end
        ST_BYP, ST_WR: begin
          if (mem_ack_i) state_q <= ST_IDLE;
        end
        ST_FILL: begin
          if (mem_ack_i) begin
            word_q  <= word_q + 1'b1;
            left_q  <= left_q - 1'b1;
            first_q <= 1'b0;
            if (left_q == CNT_W'(1)) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_store_writes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i && we_i) |=> (mem_req_o && mem_we_o))
    else $error("p_store_writes_r5");

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_we_o)))
    else $error("p_req_hold_r10");

  p_no_hit_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !enable_i) |-> !ack_o)
    else $error("p_no_hit_disabled_r9");

  p_hit_stays_local_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && ack_o) |=> !mem_req_o)
    else $error("p_hit_stays_local_r1");
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              inv_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int LA_W  = IDX_W + OFF_W;

  logic [ADDR_W-1:0]     lk_addr;
  logic [TAG_W-1:0]      rd_tag;
  logic                  rd_lvalid;
  logic [LINE_WORDS-1:0] rd_wvalid;
  logic                  lk_line, lk_hit;
  logic                  from_mem;
  logic                  upd_en, upd_new, upd_from_mem;
  logic [ADDR_W-1:0]     upd_addr;
  logic [DATA_W-1:0]     upd_wdata, arr_rdata;

  assign lk_line = rd_lvalid && (rd_tag == lk_addr[ADDR_W-1:LA_W]);
  assign lk_hit  = lk_line && rd_wvalid[lk_addr[OFF_W-1:0]];
  assign rdata_o = from_mem ? mem_rdata_i : arr_rdata;

  dc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)
  ) u_ctrl (
    .clk_i, .rst_ni, .enable_i, .req_i, .we_i, .addr_i, .wdata_i,
    .lk_hit_i       (lk_hit),
    .lk_line_i      (lk_line),
    .mem_ack_i,
    .lk_addr_o      (lk_addr),
    .ack_o,
    .from_mem_o     (from_mem),
    .upd_en_o       (upd_en),
    .upd_new_o      (upd_new),
    .upd_from_mem_o (upd_from_mem),
    .upd_addr_o     (upd_addr),
    .upd_wdata_o    (upd_wdata),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o
  );

  dc_tag_store #(
    .NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)
  ) u_tags (
    .clk_i, .rst_ni, .inv_i,
    .rd_idx_i    (lk_addr[LA_W-1:OFF_W]),
    .rd_tag_o    (rd_tag),
    .rd_lvalid_o (rd_lvalid),
    .rd_wvalid_o (rd_wvalid),
    .wr_en_i     (upd_en),
    .wr_new_i    (upd_new),
    .wr_idx_i    (upd_addr[LA_W-1:OFF_W]),
    .wr_tag_i    (upd_addr[ADDR_W-1:LA_W]),
    .wr_word_i   (upd_addr[OFF_W-1:0])
  );

  dc_data_store #(
    .NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)
  ) u_data (
    .clk_i,
    .we_i    (upd_en),
    .waddr_i (upd_addr[LA_W-1:0]),
    .wdata_i (upd_from_mem ? mem_rdata_i : upd_wdata),
    .raddr_i (lk_addr[LA_W-1:0]),
    .rdata_o (arr_rdata)
  );

  p_mem_quiet_reset_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !mem_req_o)
    else $error("p_mem_quiet_reset_r11");
endmodule

// File: tb/dcache_wt_bench.sv
module dcache_wt_bench;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int LAT = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          enable_i = 1'b1, inv_i = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          ack_o, mem_req_o, mem_we_o;
  logic [DW-1:0] rdata_o, mem_wdata_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_ack_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;

  int checks = 0, failures = 0;

  dcache_wt u_dcache_wt (.*);

  always #10 clk_i = ~clk_i;

  // memory model
  logic [DW-1:0] mem [4096];
  logic [AW-1:0] rd_log [64];
  int            rd_cnt = 0, wr_cnt = 0, lat = 0, hold_viol = 0;
  logic [AW-1:0] last_waddr = '0, held_addr = '0;
  logic [DW-1:0] last_wdata = '0;

  initial for (int i = 0; i < 4096; i++) mem[i] = (i * 32'h0101_0107) ^ 32'hA500_0000;

  always @(posedge clk_i) begin
    if (mem_ack_i) begin
      mem_ack_i <= 1'b0;
    end else if (mem_req_o) begin
      if (lat == 0) held_addr <= mem_addr_o;
      else if (mem_addr_o != held_addr) hold_viol <= hold_viol + 1;
      if (lat == LAT) begin
        lat       <= 0;
        mem_ack_i <= 1'b1;
        if (mem_we_o) begin
          mem[mem_addr_o] <= mem_wdata_o;
          last_waddr      <= mem_addr_o;
          last_wdata      <= mem_wdata_o;
          wr_cnt          <= wr_cnt + 1;
        end else begin
          mem_rdata_i            <= mem[mem_addr_o];
          rd_log[rd_cnt % 64]    <= mem_addr_o;
          rd_cnt                 <= rd_cnt + 1;
        end
      end else begin
        lat <= lat + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     output logic [DW-1:0] q, output int waits);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d; waits = 0;
    #1;
    while (!ack_o) begin
      @(negedge clk_i);
      waits++;
      #1;
    end
    q = rdata_o;
    @(posedge clk_i);
    #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic settle();
    repeat (16) @(negedge clk_i);
  endtask

  function automatic logic [AW-1:0] mk(input int tag, input int idx, input int wd);
    return AW'((tag << 6) | (idx << 2) | wd);
  endfunction

  logic [DW-1:0] q;
  int            w, n0;

  task automatic t_reset();
    @(negedge clk_i);
    chk(ack_o == 1'b0, "R11 ack low", 32'(ack_o), 0);
    chk(mem_req_o == 1'b0, "R11 mem_req low", 32'(mem_req_o), 0);
  endtask

  task automatic t_miss_fill();
    logic [AW-1:0] a;
    a = mk(5, 3, 2);
    n0 = rd_cnt;
    acc(1'b0, a, '0, q, w);
    chk(q == mem[a], "R2 critical word data", q, mem[a]);
    chk(w == 4, "R2 ack on first beat", w, 4);
    settle();
    chk(rd_cnt - n0 == 4, "R2 four reads", rd_cnt - n0, 4);
    for (int k = 0; k < 4; k++)
      chk(rd_log[(n0 + k) % 64] == mk(5, 3, (2 + k) % 4), "R2 wrap order",
          rd_log[(n0 + k) % 64], mk(5, 3, (2 + k) % 4));
    for (int k = 0; k < 4; k++) begin
      acc(1'b0, mk(5, 3, k), '0, q, w);
      chk(w == 0 && q == mem[mk(5, 3, k)], "R3 R1 filled word hits", q, mem[mk(5, 3, k)]);
    end
    chk(rd_cnt - n0 == 4, "R1 hits read nothing", rd_cnt - n0, 4);
  endtask

  task automatic t_store_hit();
    n0 = wr_cnt;
    acc(1'b1, mk(5, 3, 1), 32'hCAFE_0001, q, w);
    chk(w == 4, "R5 ack on write ack", w, 4);
    chk(wr_cnt - n0 == 1 && last_waddr == mk(5, 3, 1), "R5 write addr", last_waddr, mk(5, 3, 1));
    chk(last_wdata == 32'hCAFE_0001, "R5 write data", last_wdata, 32'hCAFE_0001);
    acc(1'b0, mk(5, 3, 1), '0, q, w);
    chk(w == 0 && q == 32'hCAFE_0001, "R6 updated word hits", q, 32'hCAFE_0001);
  endtask

  task automatic t_store_miss();
    acc(1'b1, mk(9, 3, 0), 32'hBEEF_0900, q, w);
    chk(last_waddr == mk(9, 3, 0) && last_wdata == 32'hBEEF_0900, "R5 R7 miss store written",
        last_wdata, 32'hBEEF_0900);
    acc(1'b0, mk(9, 3, 0), '0, q, w);
    chk(w == 0 && q == 32'hBEEF_0900, "R7 stored word hits", q, 32'hBEEF_0900);
    n0 = rd_cnt;
    acc(1'b0, mk(9, 3, 1), '0, q, w);
    chk(q == mem[mk(9, 3, 1)], "R4 single word data", q, mem[mk(9, 3, 1)]);
    settle();
    chk(rd_cnt - n0 == 1 && rd_log[n0 % 64] == mk(9, 3, 1), "R4 one read only",
        rd_cnt - n0, 1);
    acc(1'b0, mk(9, 3, 1), '0, q, w);
    chk(w == 0, "R4 fetched word hits", w, 0);
    acc(1'b0, mk(5, 3, 3), '0, q, w);
    chk(w != 0 && q == mem[mk(5, 3, 3)], "R7 old line replaced", w, 4);
    settle();
  endtask

  task automatic t_inv();
    acc(1'b0, mk(2, 7, 0), '0, q, w);
    settle();
    acc(1'b0, mk(2, 7, 0), '0, q, w);
    chk(w == 0, "R8 resident before invalidate", w, 0);
    @(negedge clk_i); inv_i = 1'b1;
    @(negedge clk_i); inv_i = 1'b0;
    n0 = rd_cnt;
    acc(1'b0, mk(2, 7, 0), '0, q, w);
    chk(w == 4 && q == mem[mk(2, 7, 0)], "R8 load misses after invalidate", w, 4);
    settle();
    chk(rd_cnt - n0 == 4, "R8 full refill", rd_cnt - n0, 4);
  endtask

  task automatic t_disable();
    logic [DW-1:0] old;
    acc(1'b0, mk(1, 9, 2), '0, q, w);
    settle();
    old = q;
    @(negedge clk_i); enable_i = 1'b0;
    n0 = rd_cnt;
    acc(1'b0, mk(1, 9, 2), '0, q, w);
    chk(w == 4 && q == old, "R9 bypassed load", w, 4);
    settle();
    chk(rd_cnt - n0 == 1, "R9 single word read", rd_cnt - n0, 1);
    acc(1'b1, mk(1, 9, 2), 32'h1234_5678, q, w);
    chk(last_wdata == 32'h1234_5678 && last_waddr == mk(1, 9, 2), "R9 bypassed store written",
        last_wdata, 32'h1234_5678);
    @(negedge clk_i); enable_i = 1'b1;
    acc(1'b0, mk(1, 9, 2), '0, q, w);
    chk(w == 0 && q == old, "R9 cache untouched while disabled", q, old);
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_miss_fill();
    t_store_hit();
    t_store_miss();
    t_inv();
    t_disable();
    chk(hold_viol == 0, "R10 request held stable", hold_viol, 0);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end
endmodule